// File: doc/BRIEF.md
# Mixed-Rate Horizontal Line Timer

This block generates the horizontal timing of a 320-pixel-wide video line from a single master clock. A line is made of 420 pixel slots. Most slots last 8 master clocks. A run of 30 slots inside horizontal blanking lasts 10 master clocks each, so one line takes 3420 master clocks. From its slot position the block produces four things, all registered. The first is an 8-bit horizontal counter that steps once per two slots and jumps forward inside blanking. The second is a region code for the line. The third is a set of level outputs: sync, blank and the blank status flag. The fourth is three single-clock event pulses: the horizontal interrupt, the vertical-counter step and the vertical-interrupt position.

The enable input gates the whole timer. While it is low, the slot position and every output hold, and no pulse is produced. The block has no data stream. Every pin is a plain control or status signal.

Top module: `hline_timer`

## Requirements
- R1: While reset (active low) is asserted, and before the first enabled clock, the outputs show slot 0 with the divider cleared: counter 0x00, region 5, sync 0, blank 1, blank flag 1, and all pulses 0.
- R2: Each enabled clock advances the timer by one master clock. Slots 359 to 388 last 10 master clocks and all other slots last 8, so consecutive horizontal interrupt pulses are exactly 3420 enabled clocks apart.
- R3: The counter equals slot/2 for slots 0 to 365. For slots 366 to 419 it equals 0xE5 + (slot-366)/2, which gives 0xB6 followed directly by 0xE5, and 0xFF followed by 0x00 at the wrap.
- R4: The region code is 0 for active display (slots 13 to 332), 1 for the right border (333 to 347), 2 for the back porch (348 to 356), 3 for sync (357 to 385), 4 for the front porch (386 to 419) and 5 for the left border (0 to 12).
- R5: The sync output is high exactly in slots 357 to 385.
- R6: The blank output is high in every slot outside 13 to 332. This gives 860 master clocks of blanking per line.
- R7: The blank status flag is high from slot 366, where the counter first reads 0xE5, through slot 12. It is low elsewhere.
- R8: The horizontal interrupt pulse is high for one clock, in the first master clock of slot 317, while the counter reads 0x9E.
- R9: The vertical-counter step pulse is high for one clock, in the first master clock of slot 333, together with the start of blanking.
- R10: The vertical-interrupt position pulse is high for one clock, in the last master clock of slot 407. This is the final clock at counter 0xF9, one clock before 0xFA appears.
- R11: While the enable is low, all outputs hold their values and no pulse is produced, even right after an event slot has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable, one master clock per high cycle |
| hcount_o | output | 8 | Horizontal counter |
| region_o | output | 3 | Region code (see R4) |
| hsync_o | output | 1 | Horizontal sync, active high |
| hblank_o | output | 1 | Horizontal blank |
| hblank_flag_o | output | 1 | Blank status flag |
| hint_o | output | 1 | Horizontal interrupt pulse |
| vinc_o | output | 1 | Vertical-counter step pulse |
| vint_o | output | 1 | Vertical-interrupt position pulse |

## Verification
First the enable is held high for two full lines. This exposes any error in slot lengths, the counter jump or region edges as a fixed offset from a reference of the line position. Then the enable is toggled pseudo-randomly, which separates "advances per enabled clock" from "advances per clock" and catches pulses that repeat on stalled cycles. A directed stall starts just as the horizontal interrupt slot begins, to show that a held event slot produces no second pulse. The spacing of interrupt pulses in enabled clocks confirms the 3420-clock line independently of the counter.

// File: rtl/hlt_pkg.sv
package hlt_pkg;
  typedef enum logic [2:0] {
    REG_ACTIVE  = 3'd0,
    REG_RBORDER = 3'd1,
    REG_BPORCH  = 3'd2,
    REG_SYNC    = 3'd3,
    REG_FPORCH  = 3'd4,
    REG_LBORDER = 3'd5
  } region_e;
endpackage

// File: rtl/hlt_slot_seq.sv
module hlt_slot_seq #(
  parameter int LINE_PIXELS = 420,
  parameter int SHORT_CLKS  = 8,
  parameter int LONG_CLKS   = 10,
  parameter int LONG_FIRST  = 359,
  parameter int LONG_LAST   = 388,
  localparam int PIX_W = $clog2(LINE_PIXELS),
  localparam int SUB_W = $clog2(LONG_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [PIX_W-1:0] pix_nx,
  output logic [SUB_W-1:0] sub_nx,
  output logic             step
);
  localparam logic [PIX_W-1:0] LAST_P = PIX_W'(LINE_PIXELS - 1);
  localparam logic [PIX_W-1:0] LF_P   = PIX_W'(LONG_FIRST);
  localparam logic [PIX_W-1:0] LL_P   = PIX_W'(LONG_LAST);
  localparam logic [SUB_W-1:0] SHORT_M1 = SUB_W'(SHORT_CLKS - 1);
  localparam logic [SUB_W-1:0] LONG_M1  = SUB_W'(LONG_CLKS - 1);

  logic [PIX_W-1:0] pix_q;
  logic [SUB_W-1:0] sub_q;
  logic             long_slot;
  logic [SUB_W-1:0] sub_last;

  assign long_slot = (pix_q >= LF_P) && (pix_q <= LL_P);
  assign sub_last  = long_slot ? LONG_M1 : SHORT_M1;

  always_comb begin
    pix_nx = pix_q;
    sub_nx = sub_q;
    step   = 1'b0;
    if (en) begin
      if (sub_q == sub_last) begin
        step   = 1'b1;
        sub_nx = '0;
        pix_nx = (pix_q == LAST_P) ? '0 : pix_q + 1'b1;
      end else begin
        sub_nx = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q <= '0;
      sub_q <= '0;
    end else begin
      pix_q <= pix_nx;
      sub_q <= sub_nx;
    end
  end

  // R2
  sub_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= sub_last);

  // R2
  pix_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q <= LAST_P);

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pix_q) && $stable(sub_q)));
endmodule

// File: rtl/hlt_count_map.sv
module hlt_count_map #(
  parameter int LINE_PIXELS = 420,
  parameter int JUMP_PIX    = 366,
  parameter int JUMP_BASE   = 229,
  parameter int HC_W        = 8,
  localparam int PIX_W = $clog2(LINE_PIXELS)
) (
  input  logic [PIX_W-1:0] pix,
  output logic [HC_W-1:0]  hc
);
  localparam logic [PIX_W-1:0] JP = PIX_W'(JUMP_PIX);
  localparam logic [HC_W-1:0]  JB = HC_W'(JUMP_BASE);

  logic [PIX_W-1:0] rel;

  always_comb begin
    rel = pix - JP;
    if (pix < JP) hc = HC_W'(pix >> 1);
    else          hc = JB + HC_W'(rel >> 1);
  end
endmodule

// File: rtl/hlt_region_dec.sv
module hlt_region_dec
  import hlt_pkg::*;
#(
  parameter int LINE_PIXELS = 420,
  parameter int ACT_FIRST   = 13,
  parameter int RB_FIRST    = 333,
  parameter int BP_FIRST    = 348,
  parameter int SY_FIRST    = 357,
  parameter int FP_FIRST    = 386,
  parameter int FLAG_FIRST  = 366,
  localparam int PIX_W = $clog2(LINE_PIXELS)
) (
  input  logic [PIX_W-1:0] pix,
  output region_e          region,
  output logic             sync,
  output logic             blank,
  output logic             flag
);
  localparam logic [PIX_W-1:0] A_P  = PIX_W'(ACT_FIRST);
  localparam logic [PIX_W-1:0] R_P  = PIX_W'(RB_FIRST);
  localparam logic [PIX_W-1:0] B_P  = PIX_W'(BP_FIRST);
  localparam logic [PIX_W-1:0] S_P  = PIX_W'(SY_FIRST);
  localparam logic [PIX_W-1:0] F_P  = PIX_W'(FP_FIRST);
  localparam logic [PIX_W-1:0] FL_P = PIX_W'(FLAG_FIRST);

  always_comb begin
    if (pix < A_P)      region = REG_LBORDER;
    else if (pix < R_P) region = REG_ACTIVE;
    else if (pix < B_P) region = REG_RBORDER;
    else if (pix < S_P) region = REG_BPORCH;
    else if (pix < F_P) region = REG_SYNC;
    else                region = REG_FPORCH;
    sync  = (region == REG_SYNC);
    blank = (region != REG_ACTIVE);
    flag  = (pix >= FL_P) || (pix < A_P);
  end
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hlt_pkg::*;
#(
  parameter int LINE_PIXELS = 420,
  parameter int SHORT_CLKS  = 8,
  parameter int LONG_CLKS   = 10,
  parameter int LONG_FIRST  = 359,
  parameter int LONG_LAST   = 388,
  parameter int JUMP_PIX    = 366,
  parameter int JUMP_BASE   = 229,
  parameter int HINT_PIX    = 317,
  parameter int VINC_PIX    = 333,
  parameter int VINT_PIX    = 407,
  parameter int HC_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [HC_W-1:0] hcount_o,
  output logic [2:0]      region_o,
  output logic            hsync_o,
  output logic            hblank_o,
  output logic            hblank_flag_o,
  output logic            hint_o,
  output logic            vinc_o,
  output logic            vint_o
);
  localparam int PIX_W = $clog2(LINE_PIXELS);
  localparam int SUB_W = $clog2(LONG_CLKS + 1);
  localparam logic [PIX_W-1:0] HINT_P = PIX_W'(HINT_PIX);
  localparam logic [PIX_W-1:0] VINC_P = PIX_W'(VINC_PIX);
  localparam logic [PIX_W-1:0] VINT_P = PIX_W'(VINT_PIX);
  localparam logic [SUB_W-1:0] SHORT_M1 = SUB_W'(SHORT_CLKS - 1);
  localparam logic [HC_W-1:0]  HINT_HC = HC_W'(HINT_PIX / 2);
  localparam logic [HC_W-1:0]  VINT_HC = HC_W'(JUMP_BASE + (VINT_PIX - JUMP_PIX) / 2);
  localparam logic [HC_W-1:0]  PRE_JUMP_HC = HC_W'((JUMP_PIX - 1) / 2);
  localparam logic [HC_W-1:0]  JB = HC_W'(JUMP_BASE);

  logic [PIX_W-1:0] pix_nx;
  logic [SUB_W-1:0] sub_nx;
  logic             step;
  logic [HC_W-1:0]  hc_nx;
  region_e          region_nx;
  logic             sync_nx, blank_nx, flag_nx;

  hlt_slot_seq #(
    .LINE_PIXELS(LINE_PIXELS), .SHORT_CLKS(SHORT_CLKS), .LONG_CLKS(LONG_CLKS),
    .LONG_FIRST(LONG_FIRST), .LONG_LAST(LONG_LAST)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .pix_nx(pix_nx), .sub_nx(sub_nx), .step(step)
  );

  hlt_count_map #(
    .LINE_PIXELS(LINE_PIXELS), .JUMP_PIX(JUMP_PIX), .JUMP_BASE(JUMP_BASE), .HC_W(HC_W)
  ) u_map (
    .pix(pix_nx), .hc(hc_nx)
  );

  hlt_region_dec #(
    .LINE_PIXELS(LINE_PIXELS), .FLAG_FIRST(JUMP_PIX)
  ) u_dec (
    .pix(pix_nx), .region(region_nx), .sync(sync_nx),
    .blank(blank_nx), .flag(flag_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcount_o      <= '0;
      region_o      <= REG_LBORDER;
      hsync_o       <= 1'b0;
      hblank_o      <= 1'b1;
      hblank_flag_o <= 1'b1;
      hint_o        <= 1'b0;
      vinc_o        <= 1'b0;
      vint_o        <= 1'b0;
    end else begin
      hcount_o      <= hc_nx;
      region_o      <= region_nx;
      hsync_o       <= sync_nx;
      hblank_o      <= blank_nx;
      hblank_flag_o <= flag_nx;
      hint_o        <= step && (pix_nx == HINT_P);
      vinc_o        <= step && (pix_nx == VINC_P);
      vint_o        <= en && (pix_nx == VINT_P) && (sub_nx == SHORT_M1);
    end
  end

  // R3
  count_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount_o != $past(hcount_o)) |->
      ((hcount_o == $past(hcount_o) + 1'b1) ||
       ($past(hcount_o) == PRE_JUMP_HC && hcount_o == JB)));

  // R8
  hint_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hint_o |-> (hcount_o == HINT_HC && region_o == REG_ACTIVE));

  // R8
  hint_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hint_o |=> !hint_o);

  // R9
  vinc_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vinc_o |-> (hblank_o && !hblank_flag_o && region_o == REG_RBORDER));

  // R10
  vint_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vint_o |-> hcount_o == VINT_HC);

  // R7
  flag_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_flag_o |-> hblank_o);

  // R5
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_o |-> (hblank_o && hblank_flag_o == (hcount_o >= JB)));

  // R11
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hint_o && !vinc_o && !vint_o));
endmodule

// File: tb/hline_timer_test.sv
module hline_timer_test;
  localparam int LINE_CLKS = 3420;
  localparam int T_HINT = 2536;
  localparam int T_VINC = 2664;
  localparam int T_VINT = 3323;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] hcount_o;
  logic [2:0] region_o;
  logic hsync_o, hblank_o, hblank_flag_o, hint_o, vinc_o, vint_o;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit adv = 1'b0;
  int en_edges = 0;
  int last_hint = -1;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hline_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hcount_o(hcount_o), .region_o(region_o), .hsync_o(hsync_o),
    .hblank_o(hblank_o), .hblank_flag_o(hblank_flag_o),
    .hint_o(hint_o), .vinc_o(vinc_o), .vint_o(vint_o)
  );

  function automatic int pix_of(int tt);
    if (tt < 359 * 8) return tt / 8;
    if (tt < 359 * 8 + 300) return 359 + (tt - 359 * 8) / 10;
    return 389 + (tt - 359 * 8 - 300) / 8;
  endfunction

  function automatic int hc_of(int p);
    if (p < 366) return p / 2;
    return (229 + (p - 366) / 2) % 256;
  endfunction

  function automatic int reg_of(int p);
    if (p <= 12) return 5;
    if (p <= 332) return 0;
    if (p <= 347) return 1;
    if (p <= 356) return 2;
    if (p <= 385) return 3;
    return 4;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at time %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      t <= 0;
      adv <= 1'b0;
    end else if (en) begin
      t <= (t + 1) % LINE_CLKS;
      adv <= 1'b1;
      en_edges <= en_edges + 1;
    end else begin
      adv <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p;
      p = pix_of(t);
      chk(hcount_o == 8'(hc_of(p)), "R3", "hcount", hcount_o, hc_of(p));
      chk(region_o == 3'(reg_of(p)), "R4", "region", region_o, reg_of(p));
      chk(hsync_o == (p >= 357 && p <= 385), "R5", "sync", hsync_o, int'(p >= 357 && p <= 385));
      chk(hblank_o == !(p >= 13 && p <= 332), "R6", "blank", hblank_o, int'(!(p >= 13 && p <= 332)));
      chk(hblank_flag_o == (p >= 366 || p <= 12), "R7", "flag", hblank_flag_o, int'(p >= 366 || p <= 12));
      chk(hint_o == (adv && t == T_HINT), "R8", "hint", hint_o, int'(adv && t == T_HINT));
      chk(vinc_o == (adv && t == T_VINC), "R9", "vinc", vinc_o, int'(adv && t == T_VINC));
      chk(vint_o == (adv && t == T_VINT), "R10", "vint", vint_o, int'(adv && t == T_VINT));
      if (hint_o) begin
        if (last_hint >= 0)
          chk(en_edges - last_hint == LINE_CLKS, "R2", "hint spacing", en_edges - last_hint, LINE_CLKS);
        last_hint = en_edges;
      end
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h51C0_77E5);
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(hcount_o == 8'h00, "R1", "reset hcount", hcount_o, 0);
    chk(region_o == 3'd5, "R1", "reset region", region_o, 5);
    chk(hsync_o == 1'b0, "R1", "reset sync", hsync_o, 0);
    chk(hblank_o == 1'b1, "R1", "reset blank", hblank_o, 1);
    chk(hblank_flag_o == 1'b1, "R1", "reset flag", hblank_flag_o, 1);
    chk({hint_o, vinc_o, vint_o} == 3'b000, "R1", "reset pulses", {hint_o, vinc_o, vint_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hcount_o == 8'h00 && region_o == 3'd5, "R1", "idle after reset", hcount_o, 0);
    // two full lines at full rate
    en = 1'b1;
    repeat (2 * LINE_CLKS + 10) @(negedge clk);
    // pseudo-random enable
    for (int i = 0; i < 12000; i++) begin
      en = ($urandom % 4) != 0;
      @(negedge clk);
    end
    // directed stall right after the interrupt slot begins
    en = 1'b1;
    while (!hint_o) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      // R11
      chk(!hint_o && !vinc_o && !vint_o, "R11", "pulse while idle", hint_o, 0);
      chk(hcount_o == 8'h9E, "R11", "hcount held", hcount_o, 8'h9E);
    end
    en = 1'b1;
    repeat (LINE_CLKS + 20) @(negedge clk);
    finish_run();
  end
endmodule